// File: doc/BRIEF.md
# Safety-Partitioned Interrupt Sense Converter

The converter sits in front of a downstream interrupt controller that only understands two kinds of request: an active-high level or a rising edge. It accepts sixteen external interrupt pins, one system-error input and sixteen software-triggered sources. It turns each of them into one normalized request line. Every external input is synchronized, and its sense is set by a 2-bit mode field. A low-level pin becomes an active-high level. A falling, rising or both-edge event becomes a one-cycle high pulse.

The inputs are split into two partitions, each with its own small register port. The general partition owns pins 0 to 13 and software sources 0 to 13. The safety partition owns pins 14 and 15, the error input, and software sources 14 and 15. In each partition, software sources are fired by writing ones to a trigger register. Software sources have no mode field and always behave as rising-edge sources.

Top module: `isc_top`

## Requirements
- R1: After reset every output is low and every mode field in both partitions reads 00.
- R2: `irq_out` bit order, from bit 0 upward, is: general software sources 0..13, safety software sources 14..15, general pins 0..13, safety pins 14..15, then the error input at bit 32.
- R3: Each partition has a mode register at offset 0xC with field i at bits [2i+1:2i]. In the general partition, field i serves pin i (i = 0..13). In the safety partition, fields 0 and 1 serve pins 14 and 15, and field 2 serves the error input. Register bits above the last field read as zero. A write takes effect on the next clock.
- R4: With mode 00 (low level), the output is high exactly while the synchronized input is low. An input change shows at the output after the third rising clock edge.
- R5: With mode 01 (falling edge), each high-to-low transition of the synchronized input gives a single-cycle high pulse, with the same three-edge latency.
- R6: With mode 10 (rising edge), each low-to-high transition gives a single-cycle high pulse, with the same three-edge latency.
- R7: With mode 11 (both edges), every transition in either direction gives a single-cycle high pulse, with the same three-edge latency.
- R8: Writing to offset 0x0 of a partition fires one single-cycle pulse, in the cycle after the write, on each software source whose bit is 1. Bit j is source j in the general partition and source 14+j in the safety partition. Offset 0x0 reads as zero.
- R9: A write to any offset other than 0x0 and 0xC changes nothing, and a read of any offset other than 0xC returns zero.
- R10: The input synchronizers keep sampling during reset. On the first cycle after reset release, a low-level output already reflects the input, and no edge is reported because of the reset.
- R11: The two partitions are independent: a write to one never changes the other's mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 16 | Asynchronous external interrupt pins |
| err_in | input | 1 | Asynchronous system-error input |
| gen_addr | input | 12 | General partition register offset |
| gen_we | input | 1 | General partition write strobe |
| gen_wdata | input | 32 | General partition write data |
| gen_rdata | output | 32 | General partition read data (combinational) |
| saf_addr | input | 12 | Safety partition register offset |
| saf_we | input | 1 | Safety partition write strobe |
| saf_wdata | input | 32 | Safety partition write data |
| saf_rdata | output | 32 | Safety partition read data (combinational) |
| irq_out | output | 33 | Normalized requests, ordered as in R2 |

## Verification
A corrupted mode field or a stale synchronizer stage shows up on the affected `irq_out` bit on the third edge after the next input change. It appears as a missing, doubled or inverted pulse, or as a level of the wrong polarity. A mode field that takes a wrong value also shows at once on a read of offset 0xC. A stuck trigger register produces a software pulse that lasts longer than one cycle, or a pulse with no write before it, in the cycle right after the write. The bench follows a cycle-accurate reference built from the requirements. It compares all 33 outputs on every cycle, so any such divergence is reported within three cycles of the stimulus that exposes it.

// File: rtl/isc_pkg.sv
// Shared definitions for the interrupt sense converter.
package isc_pkg;
    // Sense mode field encoding
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_FALL = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_e;

    localparam int unsigned REG_DATA_W = 32;
    localparam int unsigned TRIG_OFS   = 'h0;
    localparam int unsigned MODE_OFS   = 'hC;
endpackage

// File: rtl/isc_sense_cell.sv
// Sense cell: two-flop synchronizer, one history flop and a registered
// request output. Level-low input gives an active-high level. Any selected
// edge gives a one-cycle high pulse.
// Assumes: in_raw is asynchronous. mode_i is stable between register writes.
// The sampling chain is left out of reset on purpose, so the history holds
// the synchronized input when reset is released.
module isc_sense_cell
    import isc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_raw,
    input  logic [1:0] mode_i,
    output logic       req_o
);
    logic meta_q, sync_q, hist_q;
    logic detect;

    // Sampling chain: synchronize the input and keep one cycle of history
    always_ff @(posedge clk) begin
        meta_q <= in_raw;
        sync_q <= meta_q;
        hist_q <= sync_q;
    end

    // Select the sense condition for the programmed mode
    always_comb begin
        case (sense_e'(mode_i))
            SENSE_LOW:  detect = ~sync_q;
            SENSE_FALL: detect = hist_q & ~sync_q;
            SENSE_RISE: detect = ~hist_q & sync_q;
            SENSE_BOTH: detect = hist_q ^ sync_q;
            default:    detect = 1'b0;
        endcase
    end

    // Register the normalized request
    always_ff @(posedge clk) begin
        if (!rst_n) req_o <= 1'b0;
        else        req_o <= detect;
    end

    AST_LEVEL_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && $past(mode_i) == SENSE_LOW) |-> !hist_q); // R4
    AST_FALL_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && $past(mode_i) == SENSE_FALL) |-> (!hist_q && $past(hist_q))); // R5
    AST_RISE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && $past(mode_i) == SENSE_RISE) |-> (hist_q && !$past(hist_q))); // R6
    AST_BOTH_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && $past(mode_i) == SENSE_BOTH) |-> (hist_q != $past(hist_q))); // R7
endmodule

// File: rtl/isc_bank.sv
// Register partition: holds one mode register (2 bits per sensed input) and
// one write-1-to-fire trigger register, and instantiates a sense cell for
// every sensed input.
// Assumes: 2*N_FIELDS <= REG_DATA_W and N_SW <= REG_DATA_W. Reads are
// combinational from the offset.
module isc_bank
    import isc_pkg::*;
#(
    parameter int unsigned N_FIELDS = 14,
    parameter int unsigned N_SW     = 14,
    parameter int unsigned ADDR_W   = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_FIELDS-1:0]   raw_i,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  we,
    input  logic [REG_DATA_W-1:0] wdata,
    output logic [REG_DATA_W-1:0] rdata,
    output logic [N_FIELDS-1:0]   req_o,
    output logic [N_SW-1:0]       sw_o
);
    localparam int unsigned MODE_W = 2 * N_FIELDS;

    logic [MODE_W-1:0] mode_q;
    logic              hit_mode, hit_trig;
    logic              unused_wdata_hi;

    assign hit_mode        = (addr == ADDR_W'(MODE_OFS));
    assign hit_trig        = (addr == ADDR_W'(TRIG_OFS));
    assign unused_wdata_hi = ^wdata[REG_DATA_W-1:MODE_W];

    // Mode register: reset to level-low, load on a write to its offset
    always_ff @(posedge clk) begin
        if (!rst_n)                mode_q <= '0;
        else if (we && hit_mode)   mode_q <= wdata[MODE_W-1:0];
    end

    // Trigger register: each written 1 is held for exactly one cycle
    always_ff @(posedge clk) begin
        if (!rst_n)                sw_o <= '0;
        else if (we && hit_trig)   sw_o <= wdata[N_SW-1:0];
        else                       sw_o <= '0;
    end

    // Read mux: only the mode register is readable
    always_comb begin
        rdata = hit_mode ? REG_DATA_W'(mode_q) : '0;
    end

    for (genvar i = 0; i < N_FIELDS; i++) begin : g_cell
        isc_sense_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_raw (raw_i[i]),
            .mode_i (mode_q[2*i +: 2]),
            .req_o  (req_o[i])
        );
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mode_q == '0 && sw_o == '0 && req_o == '0)); // R1
    AST_SW_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|sw_o) |-> $past(we && hit_trig)); // R8
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !hit_mode) |=> (mode_q == $past(mode_q))); // R9
    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit_mode) |=> (rdata[MODE_W-1:0] == $past(wdata[MODE_W-1:0]) || !hit_mode)); // R3
endmodule

// File: rtl/isc_top.sv
// Top level: splits the pins between the general and the safety partition,
// appends the error input to the safety partition after its pins, and
// packs all requests into the downstream index order.
// Assumes: N_SAFE < N_PIN. The error input is the last safety field.
module isc_top
    import isc_pkg::*;
#(
    parameter int unsigned N_PIN  = 16,
    parameter int unsigned N_SAFE = 2,
    parameter int unsigned ADDR_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_PIN-1:0]       pin_in,
    input  logic                   err_in,
    input  logic [ADDR_W-1:0]      gen_addr,
    input  logic                   gen_we,
    input  logic [REG_DATA_W-1:0]  gen_wdata,
    output logic [REG_DATA_W-1:0]  gen_rdata,
    input  logic [ADDR_W-1:0]      saf_addr,
    input  logic                   saf_we,
    input  logic [REG_DATA_W-1:0]  saf_wdata,
    output logic [REG_DATA_W-1:0]  saf_rdata,
    output logic [2*N_PIN:0]       irq_out
);
    localparam int unsigned N_GEN   = N_PIN - N_SAFE;
    localparam int unsigned N_SAF_F = N_SAFE + 1;

    logic [N_GEN-1:0]   gen_req, gen_sw;
    logic [N_SAF_F-1:0] saf_req;
    logic [N_SAFE-1:0]  saf_sw;

    isc_bank #(.N_FIELDS(N_GEN), .N_SW(N_GEN), .ADDR_W(ADDR_W)) u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (pin_in[N_GEN-1:0]),
        .addr  (gen_addr),
        .we    (gen_we),
        .wdata (gen_wdata),
        .rdata (gen_rdata),
        .req_o (gen_req),
        .sw_o  (gen_sw)
    );

    isc_bank #(.N_FIELDS(N_SAF_F), .N_SW(N_SAFE), .ADDR_W(ADDR_W)) u_saf (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i ({err_in, pin_in[N_PIN-1:N_GEN]}),
        .addr  (saf_addr),
        .we    (saf_we),
        .wdata (saf_wdata),
        .rdata (saf_rdata),
        .req_o (saf_req),
        .sw_o  (saf_sw)
    );

    // Downstream order: software (general, safety), pins (general, safety), error
    assign irq_out = {saf_req, gen_req, saf_sw, gen_sw};

    AST_ERR_FROM_SAFETY: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_we && !saf_we) |=> (saf_rdata == $past(saf_rdata) || saf_addr != $past(saf_addr))); // R11
endmodule

// File: tb/test_isc_top.sv
`timescale 1ns/1ps
module test_isc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pin_in = '1;
    logic        err_in = 1'b1;
    logic [11:0] gen_addr = '0, saf_addr = '0;
    logic        gen_we = 1'b0, saf_we = 1'b0;
    logic [31:0] gen_wdata = '0, saf_wdata = '0;
    logic [31:0] gen_rdata, saf_rdata;
    logic [32:0] irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    isc_top i_isc_top (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .err_in(err_in),
        .gen_addr(gen_addr), .gen_we(gen_we), .gen_wdata(gen_wdata), .gen_rdata(gen_rdata),
        .saf_addr(saf_addr), .saf_we(saf_we), .saf_wdata(saf_wdata), .saf_rdata(saf_rdata),
        .irq_out(irq_out)
    );

    // Reference state built from the requirements
    logic [16:0] m_s1 = '1, m_s2 = '1, m_h = '1;
    logic [31:0] m_gen = '0, m_saf = '0;
    logic [32:0] exp_q[$];

    function automatic logic [1:0] mode_of(int i);
        return (i < 14) ? m_gen[2*i +: 2] : m_saf[2*(i-14) +: 2];
    endfunction

    function automatic string tag_of(int b);
        if (b < 16) return "R8";
        case (mode_of(b - 16))
            2'b00:   return "R4";
            2'b01:   return "R5";
            2'b10:   return "R6";
            default: return "R7";
        endcase
    endfunction

    // Driver side of the scoreboard: push the expected vector for every edge (R2 order)
    always @(posedge clk) begin
        logic [32:0] e;
        e = '0;
        if (rst_n) begin
            for (int i = 0; i < 17; i++) begin
                case (mode_of(i))
                    2'b00:   e[16+i] = ~m_s2[i];
                    2'b01:   e[16+i] = m_h[i] & ~m_s2[i];
                    2'b10:   e[16+i] = ~m_h[i] & m_s2[i];
                    default: e[16+i] = m_h[i] ^ m_s2[i];
                endcase
            end
            if (gen_we && gen_addr == 12'h0) e[13:0]  = gen_wdata[13:0];
            if (saf_we && saf_addr == 12'h0) e[15:14] = saf_wdata[1:0];
        end
        if (!rst_n) begin
            m_gen = '0;
            m_saf = '0;
        end else begin
            if (gen_we && gen_addr == 12'hC) m_gen = gen_wdata & 32'h0FFF_FFFF;
            if (saf_we && saf_addr == 12'hC) m_saf = saf_wdata & 32'h0000_003F;
        end
        m_h  = m_s2;
        m_s2 = m_s1;
        m_s1 = {err_in, pin_in};
        exp_q.push_back(e);
    end

    // Monitor side: pop and compare away from the active edge
    always @(negedge clk) begin
        if (!done && exp_q.size() > 0) begin
            logic [32:0] e;
            e = exp_q.pop_front();
            checks++;
            if (irq_out !== e) begin
                int b;
                b = 0;
                for (int k = 32; k >= 0; k--) if (irq_out[k] !== e[k]) b = k;
                errors++;
                $display("FAIL %s irq_out bit %0d: got %h exp %h", tag_of(b), b, irq_out, e);
            end
        end
    end

    task automatic wr(input bit saf, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        if (saf) begin saf_addr = a; saf_wdata = d; saf_we = 1'b1; end
        else     begin gen_addr = a; gen_wdata = d; gen_we = 1'b1; end
        @(negedge clk);
        saf_we = 1'b0;
        gen_we = 1'b0;
    endtask

    task automatic rd(input bit saf, input logic [11:0] a, input logic [31:0] x, input string tag);
        logic [31:0] got;
        @(negedge clk);
        if (saf) saf_addr = a; else gen_addr = a;
        #1;
        got = saf ? saf_rdata : gen_rdata;
        checks++;
        if (got !== x) begin
            errors++;
            $display("FAIL %s read bank %0d ofs %h: got %h exp %h", tag, saf, a, got, x);
        end
    endtask

    task automatic drive(input logic [16:0] v, input int cycles);
        @(negedge clk);
        {err_in, pin_in} = v;
        repeat (cycles - 1) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [16:0] lfsr;
        // R10: pin 3 held low through reset, visible on the first cycle after release
        pin_in[3] = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (irq_out !== 33'h1_0000_0000 >> 13) begin
            errors++;
            $display("FAIL R10 first cycle after reset: got %h exp %h", irq_out, 33'h0_0008_0000);
        end
        // R1: modes clear after reset
        rd(0, 12'hC, 32'h0, "R1");
        rd(1, 12'hC, 32'h0, "R1");
        drive(17'h1FFFF, 4);
        // R3: program fields; pin0 low, pin1 fall, pin2 rise, pin3 both, pin13 rise
        wr(0, 12'hC, 32'hF800_00E4);
        rd(0, 12'hC, 32'h0800_00E4, "R3");
        // R3: safety fields; pin14 fall, pin15 rise, error input both
        wr(1, 12'hC, 32'hFFFF_FF39);
        rd(1, 12'hC, 32'h0000_0039, "R3");
        // R4..R7: single transitions, then a long pseudo-random toggle run
        drive(17'h1FFF0, 6);
        drive(17'h1FFFF, 6);
        drive(17'h0000F, 6);
        drive(17'h1FFFF, 6);
        lfsr = 17'h1ACE1;
        for (int n = 0; n < 120; n++) begin
            lfsr = {lfsr[15:0], lfsr[16] ^ lfsr[13]};
            drive(lfsr, (n % 3) + 1);
        end
        drive(17'h1FFFF, 6);
        // R8: software triggers in both partitions, back to back and single
        wr(0, 12'h0, 32'hFFFF_2005);
        wr(1, 12'h0, 32'hFFFF_FFFF);
        wr(0, 12'h0, 32'h0000_0001);
        @(negedge clk);
        @(negedge clk);
        wr(0, 12'h0, 32'h0000_2000);
        wr(0, 12'h0, 32'h0000_2000);
        rd(0, 12'h0, 32'h0, "R8");
        rd(1, 12'h0, 32'h0, "R8");
        // R9: unmapped offsets ignored on write and read as zero
        wr(0, 12'h8, 32'hFFFF_FFFF);
        wr(1, 12'h4, 32'hFFFF_FFFF);
        wr(0, 12'hFFC, 32'h0000_0000);
        rd(0, 12'hC, 32'h0800_00E4, "R9");
        rd(1, 12'hC, 32'h0000_0039, "R9");
        rd(0, 12'h8, 32'h0, "R9");
        rd(1, 12'h10, 32'h0, "R9");
        // R11: partitions independent
        wr(1, 12'hC, 32'h0000_0000);
        rd(0, 12'hC, 32'h0800_00E4, "R11");
        wr(0, 12'hC, 32'h0000_0000);
        wr(1, 12'hC, 32'h0000_002A);
        rd(1, 12'hC, 32'h0000_002A, "R11");
        rd(0, 12'hC, 32'h0, "R11");
        // R2/R6: safety rising on pins 14, 15 and error input, general all level-low
        drive(17'h00000, 6);
        drive(17'h1FFFF, 6);
        for (int n = 0; n < 40; n++) begin
            lfsr = {lfsr[15:0], lfsr[16] ^ lfsr[13]};
            drive(lfsr, 1);
        end
        drive(17'h1FFFF, 8);
        finish_run();
    end
endmodule